// File: doc/BRIEF.md
# Stride-Predicting Data Prefetcher

This block watches the stream of load and store accesses from a processor core and predicts, separately for each memory instruction, the next data address that instruction will touch. Every access presents the instruction address and the data address. A small fully associative table, tagged by the instruction address, remembers the last data address and the stride of each instruction, together with a four-state confidence value. When an access leaves its entry in a state that allows prediction, the block queues a prefetch of the current address plus the stride, rounded down to a cache line.

Queued prefetches go to memory strictly in order, with only one memory request outstanding at a time. A demand miss presented by the cache always takes the memory port ahead of the queue. An external check may veto a prefetch whose address would fault. The block also reports whether an access falls into the line of a prefetch that has been sent to memory and not yet answered, so the cache can count that access as a hit.

Top module: `rpt_prefetcher`

## Requirements
- R1: After reset no memory request is raised, no demand is granted and no prefetch hit is reported.
- R2: An access whose instruction address is not in the table allocates an entry in the init state with stride 0 and makes no prediction (probe_valid low). Entries are replaced in round-robin order over the 8 entries, so once eight other instructions have allocated, an earlier instruction is forgotten.
- R3: A prediction is correct when previous address plus stride equals the current address. From init a correct access moves to steady and a wrong one moves to transient and reloads the stride with current minus previous.
- R4: From transient a correct access moves to steady and a wrong one moves to no-prediction with the stride reloaded; from no-prediction a correct access moves to transient and a wrong one stays there with the stride reloaded.
- R5: From steady a correct access stays in steady and a wrong one moves to init while keeping the old stride.
- R6: An access that hits the table and leaves its entry in any state other than no-prediction raises probe_valid in the same cycle with probe_addr equal to the current address plus the updated stride, with its low 5 bits cleared (32-byte lines), and queues that line.
- R7: A predicted line whose probe_fault input is high in that cycle is not queued.
- R8: Queued lines are sent in the order they were queued, and a new memory request is never raised while an earlier one has not been answered by mem_rsp_valid.
- R9: While dmd_valid is high and the port is free, the demand line is sent with mem_req_pf low and dmd_grant high, ahead of any queued prefetch.
- R10: acc_pf_hit is high for an access whose line equals that of a prefetch already sent and not yet answered; a line that is only waiting in the queue gives no hit.
- R11: The queue holds 30 lines; a prediction made while it is full and no line leaves in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_pc | input | 32 | Instruction address of the access |
| acc_addr | input | 32 | Data address of the access |
| acc_pf_hit | output | 1 | Access falls in the line of an issued, unanswered prefetch |
| probe_valid | output | 1 | A prediction is made this cycle |
| probe_addr | output | 32 | Line address of the prediction |
| probe_fault | input | 1 | The predicted address would fault; drop it |
| dmd_valid | input | 1 | A demand miss waits for the memory port |
| dmd_addr | input | 32 | Address of the demand miss |
| dmd_grant | output | 1 | The demand miss is sent this cycle |
| mem_req_valid | output | 1 | A memory request is sent this cycle |
| mem_req_addr | output | 32 | Line address of the request |
| mem_req_pf | output | 1 | Request is a prefetch (1) or a demand (0) |
| mem_rsp_valid | input | 1 | The outstanding request has been answered |

## Verification
A corrupted confidence state or stride in the table shows at the ports in the very cycle of the next access by the same instruction, as a wrong probe_valid or probe_addr, and one request later as an unexpected line on the memory port. A fault in the queue pointers or count appears as lines leaving out of order, duplicated or lost, which the scoreboard sees on the next memory request or at the final drain. A wrong in-flight record shows as a wrong acc_pf_hit on the next access to that line, or as a second request before the response.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } conf_e;

  // Next confidence state given whether the last guess matched.
  function automatic conf_e conf_next(input conf_e s, input logic ok);
    case (s)
      ST_INIT:   conf_next = ok ? ST_STEADY : ST_TRANS;
      ST_TRANS:  conf_next = ok ? ST_STEADY : ST_NOPRED;
      ST_STEADY: conf_next = ok ? ST_STEADY : ST_INIT;
      default:   conf_next = ok ? ST_TRANS  : ST_NOPRED;
    endcase
  endfunction

  // A miss reloads the stride everywhere except in steady.
  function automatic logic stride_reload(input conf_e s, input logic ok);
    stride_reload = !ok && (s != ST_STEADY);
  endfunction

endpackage

// File: rtl/rpt_table.sv
module rpt_table
  import rpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_addr
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              e_vld    [ENTRIES];
  logic [PC_W-1:0]   e_tag    [ENTRIES];
  logic [ADDR_W-1:0] e_prev   [ENTRIES];
  logic [ADDR_W-1:0] e_stride [ENTRIES];
  conf_e             e_st     [ENTRIES];

  logic [IW-1:0]      rr_q, rr_d;
  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0]      hit_idx, wr_idx;
  logic               lookup_hit, correct;
  conf_e              nx_st, w_st;
  logic [ADDR_W-1:0]  s_prev, s_stride, nx_stride, w_stride;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = e_vld[g] && (e_tag[g] == acc_pc);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  always_comb begin
    lookup_hit = |hit_vec;
    s_prev     = e_prev[hit_idx];
    s_stride   = e_stride[hit_idx];
    correct    = (s_prev + s_stride) == acc_addr;
    nx_st      = conf_next(e_st[hit_idx], correct);
    nx_stride  = stride_reload(e_st[hit_idx], correct) ? (acc_addr - s_prev) : s_stride;
    pred_valid = acc_valid && lookup_hit && (nx_st != ST_NOPRED);
    pred_addr  = acc_addr + nx_stride;
    wr_idx     = lookup_hit ? hit_idx : rr_q;
    w_st       = lookup_hit ? nx_st : ST_INIT;
    w_stride   = lookup_hit ? nx_stride : '0;
    rr_d       = rr_q;
    if (acc_valid && !lookup_hit) begin
      rr_d = (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vld[i]    <= 1'b0;
        e_tag[i]    <= '0;
        e_prev[i]   <= '0;
        e_stride[i] <= '0;
        e_st[i]     <= ST_INIT;
      end
    end else begin
      rr_q <= rr_d;
      if (acc_valid) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (wr_idx == IW'(i)) begin
            e_vld[i]    <= 1'b1;
            e_tag[i]    <= acc_pc;
            e_prev[i]   <= acc_addr;
            e_stride[i] <= w_stride;
            e_st[i]     <= w_st;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rpt_req_queue.sv
module rpt_req_queue #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [ADDR_W-1:0]          push_addr,
  input  logic                       pop,
  output logic                       empty,
  output logic [ADDR_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [PW-1:0]     wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q < CW'(DEPTH)) || do_pop);
    wp_d    = wp_q;
    rp_d    = rp_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot[wp_q] <= push_addr;
  end

  assign empty = (cnt_q == '0);
  assign head  = slot[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/rpt_mem_port.sv
module rpt_mem_port #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_addr,
  input  logic              q_empty,
  input  logic [ADDR_W-1:0] q_head,
  output logic              q_pop,
  input  logic              mem_rsp_valid,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_pf,
  output logic              dmd_grant,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_pf_hit
);

  localparam int OFF = $clog2(LINE_BYTES);
  localparam int LW  = ADDR_W - OFF;

  logic          busy_q, busy_d;
  logic [LW-1:0] fl_line_q, fl_line_d;
  logic          fl_pf_q, fl_pf_d;

  always_comb begin
    mem_req_valid = !busy_q && (dmd_valid || !q_empty);
    mem_req_pf    = !dmd_valid;
    mem_req_addr  = dmd_valid ? {dmd_addr[ADDR_W-1:OFF], {OFF{1'b0}}} : q_head;
    dmd_grant     = mem_req_valid && dmd_valid;
    q_pop         = mem_req_valid && !dmd_valid;
    busy_d        = busy_q;
    fl_line_d     = fl_line_q;
    fl_pf_d       = fl_pf_q;
    if (mem_req_valid) begin
      busy_d    = 1'b1;
      fl_line_d = mem_req_addr[ADDR_W-1:OFF];
      fl_pf_d   = mem_req_pf;
    end else if (mem_rsp_valid) begin
      busy_d = 1'b0;
    end
    acc_pf_hit = acc_valid && busy_q && fl_pf_q && (acc_addr[ADDR_W-1:OFF] == fl_line_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      fl_line_q <= '0;
      fl_pf_q   <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      fl_line_q <= fl_line_d;
      fl_pf_q   <= fl_pf_d;
    end
  end

endmodule

// File: rtl/rpt_prefetcher.sv
module rpt_prefetcher #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 8,
  parameter int Q_DEPTH    = 30,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_pf_hit,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_fault,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              dmd_grant,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_pf,
  input  logic              mem_rsp_valid
);

  localparam int OFF = $clog2(LINE_BYTES);
  localparam int CW  = $clog2(Q_DEPTH + 1);

  logic              pred_valid;
  logic [ADDR_W-1:0] pred_addr;
  logic              q_empty, q_pop;
  logic [ADDR_W-1:0] q_head;
  logic [CW-1:0]     q_count;

  rpt_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_pc     (acc_pc),
    .acc_addr   (acc_addr),
    .pred_valid (pred_valid),
    .pred_addr  (pred_addr)
  );

  assign probe_valid = pred_valid;
  assign probe_addr  = {pred_addr[ADDR_W-1:OFF], {OFF{1'b0}}};

  rpt_req_queue #(.ADDR_W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pred_valid && !probe_fault),
    .push_addr (probe_addr),
    .pop       (q_pop),
    .empty     (q_empty),
    .head      (q_head),
    .count     (q_count)
  );

  rpt_mem_port #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .dmd_valid     (dmd_valid),
    .dmd_addr      (dmd_addr),
    .q_empty       (q_empty),
    .q_head        (q_head),
    .q_pop         (q_pop),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_pf    (mem_req_pf),
    .dmd_grant     (dmd_grant),
    .acc_valid     (acc_valid),
    .acc_addr      (acc_addr),
    .acc_pf_hit    (acc_pf_hit)
  );

endmodule

// File: rtl/rpt_prefetcher_chk.sv
module rpt_prefetcher_chk #(
  parameter int Q_DEPTH = 30
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         acc_valid,
  input logic                         acc_pf_hit,
  input logic                         probe_valid,
  input logic                         probe_fault,
  input logic                         dmd_valid,
  input logic                         dmd_grant,
  input logic                         mem_req_valid,
  input logic                         mem_req_pf,
  input logic                         mem_rsp_valid,
  input logic [$clog2(Q_DEPTH+1)-1:0] q_count
);

  localparam int CW = $clog2(Q_DEPTH + 1);

  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             outst <= 1'b0;
    else if (mem_req_valid) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid);  // R8

  AST_DEMAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_valid && mem_req_valid) |-> (!mem_req_pf && dmd_grant));  // R9

  AST_DEMAND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_valid && !outst) |-> dmd_grant);  // R9

  AST_HIT_NEEDS_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pf_hit |-> (outst && acc_valid));  // R10

  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && probe_valid && probe_fault) |=> (q_count <= $past(q_count)));  // R7

  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(Q_DEPTH));  // R11

endmodule

bind rpt_prefetcher rpt_prefetcher_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_pf_hit    (acc_pf_hit),
  .probe_valid   (probe_valid),
  .probe_fault   (probe_fault),
  .dmd_valid     (dmd_valid),
  .dmd_grant     (dmd_grant),
  .mem_req_valid (mem_req_valid),
  .mem_req_pf    (mem_req_pf),
  .mem_rsp_valid (mem_rsp_valid),
  .q_count       (q_count)
);

// File: tb/tb_rpt_prefetcher.sv
`timescale 1ns/1ps
module tb_rpt_prefetcher;

  localparam int NENT = 8;
  localparam int QD   = 30;
  localparam int LAT  = 3;

  logic        clk, rst_n;
  logic        acc_valid, probe_fault, dmd_valid, mem_rsp_valid;
  logic [31:0] acc_pc, acc_addr, dmd_addr;
  logic        acc_pf_hit, probe_valid, dmd_grant, mem_req_valid, mem_req_pf;
  logic [31:0] probe_addr, mem_req_addr;

  rpt_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .acc_pf_hit(acc_pf_hit), .probe_valid(probe_valid), .probe_addr(probe_addr),
    .probe_fault(probe_fault), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr), .dmd_grant(dmd_grant),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
    .mem_rsp_valid(mem_rsp_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic        m_vld [NENT];
  logic [31:0] m_tag [NENT], m_prev [NENT], m_str [NENT];
  int          m_st  [NENT];   // 0 init, 1 transient, 2 steady, 3 no-prediction
  int          m_rr = 0;
  int          pf_pushed = 0, pf_popped = 0;
  logic [31:0] pfq[$];
  logic [31:0] dq[$];

  // bench view of the memory port
  bit          outst = 0, rsp_en = 1, fl_pf = 0;
  logic [31:0] fl_line = '0;
  int          lat = 0;

  function automatic logic [31:0] ln(input logic [31:0] a);
    return {a[31:5], 5'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, predicts probe/hit, then commits model and pushes expected line
  task automatic do_acc(input logic [31:0] pc, input logic [31:0] a, input bit flt, input string tag);
    int idx; bit hit, ok, pred, exp_hit; int nst; logic [31:0] nstr;
    @(negedge clk); #1;
    acc_valid = 1; acc_pc = pc; acc_addr = a; probe_fault = flt;
    idx = -1;
    for (int i = 0; i < NENT; i++) if (m_vld[i] && m_tag[i] == pc) idx = i;
    hit = (idx >= 0);
    pred = 0; nst = 0; nstr = '0;
    if (hit) begin
      ok = (m_prev[idx] + m_str[idx]) == a;
      case (m_st[idx])
        0: nst = ok ? 2 : 1;
        1: nst = ok ? 2 : 3;
        2: nst = ok ? 2 : 0;
        default: nst = ok ? 1 : 3;
      endcase
      nstr = (!ok && m_st[idx] != 2) ? a - m_prev[idx] : m_str[idx];
      pred = (nst != 3);
    end
    exp_hit = outst && fl_pf && (ln(a) == fl_line);
    #4;
    check(probe_valid == pred, {tag, " probe_valid"}, 32'(probe_valid), 32'(pred));
    if (pred) check(probe_addr == ln(a + nstr), {tag, " probe_addr"}, probe_addr, ln(a + nstr));
    check(acc_pf_hit == exp_hit, {tag, " acc_pf_hit"}, 32'(acc_pf_hit), 32'(exp_hit));
    #4;
    if (hit) begin
      m_st[idx] = nst; m_str[idx] = nstr; m_prev[idx] = a;
      if (pred && !flt && (pf_pushed - pf_popped) < QD) begin
        pfq.push_back(ln(a + nstr)); pf_pushed++;
      end
    end else begin
      m_vld[m_rr] = 1; m_tag[m_rr] = pc; m_prev[m_rr] = a; m_str[m_rr] = '0; m_st[m_rr] = 0;
      m_rr = (m_rr + 1) % NENT;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; acc_valid = 0; probe_fault = 0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    idle(1);
    while ((pfq.size() != 0 || dq.size() != 0 || outst) && guard < 3000) begin
      idle(1); guard++;
    end
    idle(2);
  endtask

  task automatic demand(input logic [31:0] a);
    bit g;
    dq.push_back(ln(a));
    @(negedge clk); #1; dmd_valid = 1; dmd_addr = a;
    do begin @(negedge clk); #8; g = dmd_grant; end while (!g);
    @(negedge clk); #1; dmd_valid = 0;
  endtask

  // monitor: pops expected lines as the design sends them; also plays the memory
  initial begin
    forever begin
      @(negedge clk); #8;
      if (mem_rsp_valid) mem_rsp_valid = 0;
      if (rst_n && mem_req_valid) begin
        check(!outst, "R8 request while one outstanding", 32'(outst), 32'd0);
        if (dmd_valid) check(!mem_req_pf, "R9 demand precedence", 32'(mem_req_pf), 32'd0);
        if (mem_req_pf) begin
          if (pfq.size() == 0) check(0, "R8 unexpected prefetch", mem_req_addr, 32'hFFFF_FFFF);
          else begin
            check(mem_req_addr == pfq[0], "R6 R8 prefetch line", mem_req_addr, pfq[0]);
            void'(pfq.pop_front()); pf_popped++;
          end
        end else begin
          if (dq.size() == 0) check(0, "R9 unexpected demand", mem_req_addr, 32'hFFFF_FFFF);
          else begin
            check(mem_req_addr == dq[0], "R9 demand line", mem_req_addr, dq[0]);
            void'(dq.pop_front());
          end
        end
        outst = 1; lat = LAT; fl_line = mem_req_addr; fl_pf = mem_req_pf;
      end else if (outst && rsp_en) begin
        if (lat == 0) begin mem_rsp_valid = 1; outst = 0; end
        else lat--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_prev[i] = '0; m_str[i] = '0; m_st[i] = 0; end
    rst_n = 0; acc_valid = 0; acc_pc = '0; acc_addr = '0; probe_fault = 0;
    dmd_valid = 0; dmd_addr = '0; mem_rsp_valid = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    check(mem_req_valid == 0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    check(dmd_grant == 0,     "R1 dmd_grant",     32'(dmd_grant),     32'd0);
    check(acc_pf_hit == 0,    "R1 acc_pf_hit",    32'(acc_pf_hit),    32'd0);

    // init -> transient -> steady, constant stride
    do_acc(32'h100, 32'h1000, 0, "R2");
    do_acc(32'h100, 32'h1040, 0, "R3");
    do_acc(32'h100, 32'h1080, 0, "R3");
    do_acc(32'h100, 32'h10C0, 0, "R6");
    // steady miss keeps stride, goes to init
    do_acc(32'h100, 32'h2000, 0, "R5");
    do_acc(32'h100, 32'h2040, 0, "R5");
    drain();

    // transient and no-prediction paths
    do_acc(32'h200, 32'h3000, 0, "R2");
    do_acc(32'h200, 32'h3100, 0, "R3");
    do_acc(32'h200, 32'h3500, 0, "R4");
    do_acc(32'h200, 32'h3900, 0, "R4");
    do_acc(32'h200, 32'h4000, 0, "R4");
    do_acc(32'h200, 32'h4010, 0, "R4");
    do_acc(32'h200, 32'h4020, 0, "R4");
    drain();

    // fault veto
    do_acc(32'h100, 32'h2080, 1, "R7");
    do_acc(32'h100, 32'h20C0, 0, "R7");
    drain();

    // round-robin eviction
    for (int k = 0; k < 8; k++) do_acc(32'h1000 + 32'(k * 4), 32'h6000 + 32'(k * 32'h100), 0, "R2");
    do_acc(32'h100, 32'h2100, 0, "R2");
    do_acc(32'h100, 32'h2140, 0, "R2");
    drain();

    // demand precedence over queued prefetches
    rsp_en = 0;
    for (int k = 0; k < 6; k++) do_acc(32'h300, 32'h7000 + 32'(k * 32'h20), 0, "R9");
    idle(1);
    fork
      demand(32'h9004);
      begin idle(3); rsp_en = 1; end
    join
    drain();

    // in-flight versus queued line
    rsp_en = 0;
    do_acc(32'h400, 32'h5000, 0, "R10");
    do_acc(32'h400, 32'h5020, 0, "R10");
    idle(2);
    do_acc(32'h400, 32'h5044, 0, "R10");
    do_acc(32'h410, 32'h5060, 0, "R10");
    do_acc(32'h420, 32'h5100, 0, "R10");
    rsp_en = 1;
    drain();

    // queue overflow
    rsp_en = 0;
    for (int k = 0; k < 40; k++) do_acc(32'h500, 32'h8000 + 32'(k * 32'h20), 0, "R11");
    idle(2);
    rsp_en = 1;
    drain();
    check(pfq.size() == 0, "R11 all expected lines seen", 32'(pfq.size()), 32'd0);
    check(dq.size() == 0,  "R9 all demands seen",         32'(dq.size()),  32'd0);
    check(pf_popped == pf_pushed, "R11 sent equals accepted", 32'(pf_popped), 32'(pf_pushed));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule